// File: doc/BRIEF.md
# Dual 8-bit Match Timer with Input Capture

This block holds two 8-bit up-counters that share one free-running prescaler. Each counter picks its count clock from seven power-of-two divisions of the system clock or from rising edges on an external count pin. In match mode a counter climbs to its compare value, returns to zero on the following count and raises a one-cycle match pulse, so the interval between pulses is (compare + 1) count clocks. In capture mode the counter runs freely through its full range. A rising edge on that timer's capture pin copies the live count into a capture register and raises a one-cycle capture pulse.

The two counters can be chained into one 16-bit counter. The low counter supplies the clock, the run and capture controls, and the pulses. The high counter advances when the low counter rolls over. Software writes the control and compare registers through a simple write port and reads every register through a combinational read port.

Register map (3-bit address): 0 control L, 1 compare L, 2 control H, 3 compare H, 4 capture L, 5 capture H, 6 count L, 7 count H. Control bits: [0] run, [1] clear (write-only, reads back 0), [4:2] clock select, [5] capture mode, [6] chain (honoured only in control H), [7] spare storage.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all eight read addresses return 00h and every match and capture pulse output is low.
- R2: Clock-select codes 0 to 6 divide the system clock by 2, 4, 8, 32, 128, 512 and 2048. In match mode, successive match pulses are (compare + 1) × divisor cycles apart. For example, /32 with compare 124 gives 4000 cycles.
- R3: A match pulse lasts exactly one cycle. The count reads zero in the cycle the pulse is high.
- R4: With compare value 0, a match pulse occurs on every count clock (every divisor cycles).
- R5: Clock-select code 7 counts rising edges of the external count pin after a two-flop synchroniser. With an edge every 8 cycles and compare 3, the pulses are 32 cycles apart.
- R6: While run (control bit 0) is 0 and no clear is written, the count holds its value.
- R7: Writing a control word with bit 1 set zeroes that counter at the next clock edge. Bit 1 reads back as 0.
- R8: With chain (control H bit 6) set, the pair forms a 16-bit counter {H,L} clocked by the L selection. Match pulses on match_irq[0] are (compare16 + 1) × divisor cycles apart. match_irq[1] and cap_irq[1] stay low.
- R9: In capture mode (control bit 5), match pulses are suppressed and the count wraps freely. A rise on the timer's capture pin raises the capture pulse on the third clock edge after the rise. At that edge the capture register takes the count that was readable after the second edge.
- R10: With chain and capture mode both set on L, a rise on cap_pin[0] loads the full 16-bit count into capture L (low byte) and capture H (high byte).
- R11: The counter keeps counting after a capture. With divisor 2, the count readable 10 cycles after the captured sample is the captured value + 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cnt_pin | input | 1 | External count clock (asynchronous) |
| cap_pin | input | 2 | Capture trigger per timer (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| match_irq | output | 2 | One-cycle match pulse per timer |
| cap_irq | output | 2 | One-cycle capture pulse per timer |

## Verification
Register writes take effect at the clock edge that samples the strobe. Reads are combinational, so the bench reads half a cycle after each edge. Match results are checked as intervals between pulses, not absolute times. A scoreboard discards the first pulse after each restart, because the shared prescaler phase is unknown, and compares each later spacing with the queued (compare + 1) × divisor value. A capture is due two edges after the pin rises for the sampled count and three edges after for the pulse and register. The bench reads the count in the exact half-cycle given in R9 and checks the pulse at the edges before, during and after.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CW      = 8;   // counter and bus width
  localparam int N_LANES = 2;   // counters in the pair
  localparam int AW      = 3;   // register address width
  localparam int PRE_W   = 11;  // prescaler width, covers /2048

  typedef enum logic [2:0] {
    CS_D2 = 3'd0, CS_D4, CS_D8, CS_D32, CS_D128, CS_D512, CS_D2048, CS_EXT
  } clk_sel_e;

  typedef struct packed {
    logic     spare;    // bit 7
    logic     chain;    // bit 6
    logic     capmode;  // bit 5
    clk_sel_e sel;      // bits 4:2
    logic     clr;      // bit 1
    logic     run;      // bit 0
  } ctrl_t;

  // log2 of the division for each internal clock select code
  function automatic int div_shift(input clk_sel_e s);
    case (s)
      CS_D2:    return 1;
      CS_D4:    return 2;
      CS_D8:    return 3;
      CS_D32:   return 5;
      CS_D128:  return 7;
      CS_D512:  return 9;
      default:  return 11;
    endcase
  endfunction

  // one-cycle tick each time the low div_shift bits of the prescaler are all ones
  function automatic logic presc_tick(input logic [PRE_W-1:0] p, input clk_sel_e s);
    logic [PRE_W-1:0] m;
    int sh;
    sh = div_shift(s);
    m  = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < sh) m[i] = 1'b1;
    return (p & m) == m;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tmr_lane.sv
module tmr_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         zero,
  input  logic         cap_ld,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (zero) cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cap <= '0;
    else if (cap_ld) cap <= cnt;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_cnt_pin,
  input  logic [N_LANES-1:0] cap_pin,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [CW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [CW-1:0]      rd_data,
  output logic [N_LANES-1:0] match_irq,
  output logic [N_LANES-1:0] cap_irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t                       ctrl_q [N_LANES];
  logic [N_LANES-1:0][CW-1:0]  cmp_q;
  logic [N_LANES-1:0][CW-1:0]  cnt;
  logic [N_LANES-1:0][CW-1:0]  cap;
  logic [PRE_W-1:0]            pre_cnt;
  logic                        ext_rise;
  logic [N_LANES-1:0]          cap_rise;
  logic [N_LANES-1:0]          clr_ev, tick, hit, inc, zero, cap_ld;
  logic [N_LANES-1:0]          match_ev, cap_ev;
  logic                        chain, hit16;

  tmr_prescaler #(.W(PRE_W)) pre_i (.clk(clk), .rst_n(rst_n), .cnt(pre_cnt));

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) ext_sync_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_cnt_pin), .rise(ext_rise));

  // register writes; clear is an event, never stored
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_LANES; i++) begin
        ctrl_q[i] <= '0;
        cmp_q[i]  <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < N_LANES; i++) begin
        if (wr_addr == AW'(2 * i)) begin
          ctrl_q[i]     <= ctrl_t'(wr_data[CTRL_W-1:0]);
          ctrl_q[i].clr <= 1'b0;
        end
        if (wr_addr == AW'(2 * i + 1)) cmp_q[i] <= wr_data;
      end
    end

  assign chain = ctrl_q[1].chain;
  assign hit16 = !ctrl_q[0].capmode && ({cnt[1], cnt[0]} == {cmp_q[1], cmp_q[0]});

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) cap_sync_i (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[g]), .rise(cap_rise[g]));

    assign clr_ev[g] = wr_en && (wr_addr == AW'(2 * g)) && wr_data[1];
    assign tick[g]   = ctrl_q[g].run &&
                       ((ctrl_q[g].sel == CS_EXT) ? ext_rise : presc_tick(pre_cnt, ctrl_q[g].sel));

    tmr_lane #(.W(CW)) lane_i (
      .clk(clk), .rst_n(rst_n), .inc(inc[g]), .zero(zero[g]),
      .cap_ld(cap_ld[g]), .cnt(cnt[g]), .cap(cap[g]));
  end

  // next-count control: separate lanes, or one 16-bit chain driven by lane 0
  always_comb begin
    for (int i = 0; i < N_LANES; i++) begin
      hit[i]      = !ctrl_q[i].capmode && (cnt[i] == cmp_q[i]);
      match_ev[i] = tick[i] & hit[i];
      zero[i]     = clr_ev[i] | match_ev[i];
      inc[i]      = tick[i] & ~hit[i];
      cap_ev[i]   = cap_rise[i] & ctrl_q[i].capmode;
      cap_ld[i]   = cap_ev[i];
    end
    if (chain) begin
      match_ev[0] = tick[0] & hit16;
      match_ev[1] = 1'b0;
      zero[0]     = clr_ev[0] | match_ev[0];
      zero[1]     = clr_ev[0] | clr_ev[1] | match_ev[0];
      inc[0]      = tick[0] & ~hit16;
      inc[1]      = tick[0] & ~hit16 & (cnt[0] == {CW{1'b1}});
      cap_ev[1]   = 1'b0;
      cap_ld[0]   = cap_ev[0];
      cap_ld[1]   = cap_ev[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      match_irq <= '0;
      cap_irq   <= '0;
    end else begin
      match_irq <= match_ev;
      cap_irq   <= cap_ev;
    end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = CW'(ctrl_q[0]);
      3'd1:    rd_data = cmp_q[0];
      3'd2:    rd_data = CW'(ctrl_q[1]);
      3'd3:    rd_data = cmp_q[1];
      3'd4:    rd_data = cap[0];
      3'd5:    rd_data = cap[1];
      3'd6:    rd_data = cnt[0];
      default: rd_data = cnt[1];
    endcase
  end

  // named internal events for the bound checker
  logic [CW-1:0] cnt_lo, cap_lo;
  logic          run_lo, clr_lo_ev, capm_lo;
  assign cnt_lo    = cnt[0];
  assign cap_lo    = cap[0];
  assign run_lo    = ctrl_q[0].run;
  assign clr_lo_ev = clr_ev[0];
  assign capm_lo   = ctrl_q[0].capmode;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    match_irq,
  input logic [1:0]    cap_irq,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cap_lo,
  input logic          run_lo,
  input logic          clr_lo_ev,
  input logic          capm_lo,
  input logic          chain
);
  // R3
  match_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq[0] |=> !match_irq[0]);

  // R3
  match_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq[0] |-> cnt_lo == '0);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_lo && !clr_lo_ev) |=> $stable(cnt_lo));

  // R9
  capmode_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capm_lo && $past(capm_lo)) |-> !match_irq[0]);

  // R8
  chain_hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && $past(chain)) |-> (!match_irq[1] && !cap_irq[1]));

  // R9
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq[0] |-> cap_lo == $past(cnt_lo));
endmodule

bind tmr_pair tmr_pair_chk #(.CW(tmr_pkg::CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .match_irq(match_irq), .cap_irq(cap_irq),
  .cnt_lo(cnt_lo), .cap_lo(cap_lo), .run_lo(run_lo), .clr_lo_ev(clr_lo_ev),
  .capm_lo(capm_lo), .chain(chain));

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_cnt_pin = 1'b0;
  logic [1:0] cap_pin = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic [1:0] match_irq, cap_irq;

  int n_chk = 0, n_fail = 0;
  bit ext_en = 1'b0;

  // scoreboard state
  int unsigned sb_q[$];
  string       sb_tag = "R2";
  int          mon_ch = 0;
  bit          sb_skip = 1'b0;
  bit          have_last = 1'b0;
  longint      cyc = 0, last_t = 0;
  int          lo_m = 0, hi_m = 0, cap_seen0 = 0, cap_seen1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair dut_i (
    .clk(clk), .rst_n(rst_n), .ext_cnt_pin(ext_cnt_pin), .cap_pin(cap_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .match_irq(match_irq), .cap_irq(cap_irq));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // monitor: measures spacing of match pulses and pops expected values
  always @(negedge clk) begin
    cyc++;
    if (match_irq[0]) lo_m++;
    if (match_irq[1]) hi_m++;
    if (cap_irq[0]) cap_seen0++;
    if (cap_irq[1]) cap_seen1++;
    if (match_irq[mon_ch]) begin
      if (sb_skip) begin
        sb_skip = 1'b0;
      end else if (sb_q.size() != 0 && have_last) begin
        int unsigned e;
        e = sb_q.pop_front();
        chk((cyc - last_t) == longint'(e), sb_tag, cyc - last_t, e);
      end
      last_t = cyc;
      have_last = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // external count source: one rising edge every 8 cycles when enabled
  initial forever begin
    repeat (4) @(negedge clk);
    if (ext_en) ext_cnt_pin = ~ext_cnt_pin;
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rd_addr = 3'(a);
    #1;
    d = rd_data;
  endtask

  function automatic int div_of(input int sel);
    int r;
    r = 2;
    for (int k = 0; k < sel; k++) r = (k == 2 || k >= 3) ? r * 4 : r * 2;
    return r;
  endfunction

  // driver: stop and clear, queue the expected spacings, then start
  task automatic run_sb(input int ch, input logic [7:0] ctrl_run, input int unsigned exp_per,
                        input int n, input string tag);
    wr(2 * ch, 8'h02);
    mon_ch = ch;
    repeat (3) @(negedge clk);
    sb_tag = tag;
    for (int k = 0; k < n; k++) sb_q.push_back(exp_per);
    sb_skip = 1'b1;
    wr(2 * ch, ctrl_run | 8'h02);
    while (sb_q.size() != 0) @(negedge clk);
    wr(2 * ch, 8'h00);
  endtask

  function automatic logic [7:0] mk(input int sel, input bit run, input bit capm, input bit chn);
    return {1'b0, chn, capm, 3'(sel), 1'b0, run};
  endfunction

  initial begin
    logic [7:0] v, v_exp, lo, hi, clo, chi;
    int m0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk(v == 8'h00, "R1", v, 0);
    end
    chk(match_irq == 2'b00 && cap_irq == 2'b00, "R1", {match_irq, cap_irq}, 0);

    // R2 every internal divisor, both lanes
    wr(1, 8'd124); run_sb(0, mk(3, 1, 0, 0), 125 * 32, 2, "R2");
    wr(1, 8'd9);   run_sb(0, mk(0, 1, 0, 0), 10 * div_of(0), 3, "R2");
    wr(1, 8'd1);   run_sb(0, mk(6, 1, 0, 0), 2 * 2048, 2, "R2");
    wr(3, 8'd7);   run_sb(1, mk(1, 1, 0, 0), 8 * 4, 3, "R2");
    wr(3, 8'd5);   run_sb(1, mk(2, 1, 0, 0), 6 * 8, 3, "R2");
    wr(3, 8'd3);   run_sb(1, mk(4, 1, 0, 0), 4 * 128, 2, "R2");
    wr(3, 8'd2);   run_sb(1, mk(5, 1, 0, 0), 3 * 512, 2, "R2");

    // R4 compare zero gives a pulse on every count clock
    wr(1, 8'd0);   run_sb(0, mk(0, 1, 0, 0), 2, 4, "R4");
    wr(3, 8'd0);   run_sb(1, mk(2, 1, 0, 0), 8, 3, "R4");

    // R5 external count pin
    ext_en = 1'b1;
    wr(1, 8'd3);   run_sb(0, mk(7, 1, 0, 0), 32, 3, "R5");
    ext_en = 1'b0;

    // R8 chained 16-bit match
    wr(1, 8'h23); wr(3, 8'h01); wr(2, mk(0, 0, 0, 1));
    m0 = hi_m;
    run_sb(0, mk(0, 1, 0, 0), 16'h0124 * 2, 2, "R8");
    chk(hi_m == m0, "R8", hi_m - m0, 0);
    wr(2, 8'h00);

    // R6 hold while stopped
    wr(1, 8'hFF);
    wr(0, mk(0, 1, 0, 0) | 8'h02);
    repeat (30) @(negedge clk);
    wr(0, mk(0, 0, 0, 0));
    rd(6, lo);
    chk(lo != 8'h00, "R6", lo, 1);
    repeat (20) @(negedge clk);
    rd(6, v);
    chk(v == lo, "R6", v, lo);

    // R7 clear event, bit reads back as zero
    wr(0, mk(2, 0, 0, 0) | 8'h02);
    rd(6, v);
    chk(v == 8'h00, "R7", v, 0);
    rd(0, v);
    chk(v == mk(2, 0, 0, 0), "R7", v, mk(2, 0, 0, 0));

    // R9 capture mode suppresses match pulses
    wr(1, 8'h00);
    wr(0, mk(0, 1, 1, 0) | 8'h02);
    repeat (3) @(negedge clk);
    m0 = lo_m;
    repeat (600) @(negedge clk);
    chk(lo_m == m0, "R9", lo_m - m0, 0);

    // R9 capture latency and value, R11 keeps counting
    c1 = cap_seen0;
    @(negedge clk); cap_pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(6, v_exp);
    chk(cap_irq[0] == 1'b0, "R9", cap_irq[0], 0);
    @(negedge clk);
    chk(cap_irq[0] == 1'b1, "R9", cap_irq[0], 1);
    rd(4, v);
    chk(v == v_exp, "R9", v, v_exp);
    @(negedge clk);
    chk(cap_irq[0] == 1'b0, "R9", cap_irq[0], 0);
    cap_pin[0] = 1'b0;
    repeat (8) @(negedge clk);
    rd(6, v);
    chk(v == 8'(v_exp + 8'd5), "R11", v, 8'(v_exp + 8'd5));
    chk(cap_seen0 == c1 + 1, "R9", cap_seen0 - c1, 1);

    // R10 chained capture of all 16 bits
    wr(2, mk(0, 0, 0, 1));
    wr(0, mk(0, 1, 1, 0) | 8'h02);
    repeat (700) @(negedge clk);
    wr(0, mk(0, 0, 1, 0));
    rd(6, lo);
    rd(7, hi);
    chk(hi != 8'h00, "R10", hi, 1);
    c1 = cap_seen1;
    cap_pin = 2'b11;
    repeat (5) @(negedge clk);
    rd(4, clo);
    rd(5, chi);
    chk({chi, clo} == {hi, lo}, "R10", {chi, clo}, {hi, lo});
    chk(cap_seen1 == c1, "R8", cap_seen1 - c1, 0);
    cap_pin = 2'b00;

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule